// File: doc/BRIEF.md
# Dual-Comparator Compare-Match Timer

This block is a 16-bit up-counter that advances once for each cycle in which the timer clock enable is high. Two comparators watch it. The A comparator checks the full count against a 16-bit value. The P comparator checks only the top eight bits of the count against an 8-bit value. This means P periods come in steps of 256 ticks, and a P value of zero gives the full 65536-tick wrap. A clear-select bit chooses which match resets the count. Each match sets its own sticky flag. When the A comparator is chosen to clear, the P flag is never raised.

Software programs the block through a small write port at three addresses: control, the A compare value and the P compare value. In compare-output mode, each A match drives an output pin with a programmable action. While the timer is disabled, the pin takes a programmable starting level. The timer/counter mode counts, clears and flags in the same way but leaves the pin alone. The two remaining mode codes are decoded and keep the counter parked at zero. The bit that swaps the duty and period roles of the two compare values is stored and brought out on a port.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, the count, both flags, the pin, the role-swap output and every programmable field are zero.
- R2: While the enable bit (control bit 4) is 0, the count is held at zero and the pin loads the starting level (control bit 7) on every clock.
- R3: The count advances by one only on clocks where the tick input is high, and only in mode 00 (compare output) or mode 11 (timer/counter). Mode 01 and mode 10 (control bits 1:0) hold the count at zero, and neither flag is raised.
- R4: With the clear-select bit (control bit 2) at 0 and a P value N from 1 to 255, the count runs from 0 to N*256-1. On the tick after that it returns to 0 and the P flag is set.
- R5: With the clear-select bit at 0 and a P value of 0, the count runs to 16'hFFFF. It then wraps to 0 and sets the P flag, giving a 65536-tick period.
- R6: With the clear-select bit at 1 and an A value M, the count goes from M-1 to 0 on the next tick, and the A flag is set. The P flag is never set in this setting, even when the P threshold lies below M.
- R7: With the clear-select bit at 0, the A flag is set on the tick where the count steps to the A value, and the count keeps running.
- R8: An A value of zero never produces an A match, so the A flag stays clear.
- R9: The flags are sticky. A high on a flag-clear input clears its flag at the next clock, but a match in that same clock wins and leaves the flag set.
- R10: In mode 00, each A match applies the pin action from control bits 6:5: 00 keeps the pin, 01 drives it low, 10 drives it high, 11 inverts it.
- R11: In mode 11, A matches clear the count and set the A flag, but they leave the pin unchanged.
- R12: Control bit 3 is stored and shown on the role-swap output one clock after it is written.
- R13: Writes land at the next clock edge. Address 0 is control, address 1 is the A value, and address 2 is the P value, which keeps only data bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer clock enable; one count step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 control, 1 A value, 2 P value) |
| wr_data_i | input | 16 | Register write data |
| flag_clr_a_i | input | 1 | Clears the A-match flag |
| flag_clr_p_i | input | 1 | Clears the P-match flag |
| count_o | output | 16 | Current count |
| flag_a_o | output | 1 | Sticky A-match flag |
| flag_p_o | output | 1 | Sticky P-match flag |
| cmp_pin_o | output | 1 | Compare output pin |
| roles_swap_o | output | 1 | Stored duty/period role swap bit |

## Verification
The bench targets the P threshold boundary at N*256-1. A design that compares the P value against the low byte, or that matches one count late, would show a period of N+1 ticks or N*256+1 ticks instead of N*256. It runs the full 65536-tick wrap with both compare values at zero. A design that treats a zero P value as "match at zero" would clear early, and one that lets a zero A value match would raise the A flag. With the A comparator chosen to clear and the P threshold passed on the way, a design that still raised the P flag would be caught. The random phase also hits flag-clear pulses that land on a match, the pin actions in both counting modes, and configuration writes made while the counter runs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_CMP = 2'b00,
        MODE_CAP = 2'b01,
        MODE_PWM = 2'b10,
        MODE_TMR = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        PIN_KEEP = 2'b00,
        PIN_LOW  = 2'b01,
        PIN_HIGH = 2'b10,
        PIN_FLIP = 2'b11
    } pin_act_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CCRA = 2'd1;
    localparam logic [1:0] ADDR_CCRP = 2'd2;

    localparam int CTL_MODE_LSB = 0;
    localparam int CTL_CLRSEL   = 2;
    localparam int CTL_SWAP     = 3;
    localparam int CTL_EN       = 4;
    localparam int CTL_ACT_LSB  = 5;
    localparam int CTL_INIT     = 7;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output tmr_mode_e        mode,
    output logic             clr_sel,
    output logic             swap,
    output logic             en,
    output pin_act_e         act,
    output logic             init_lvl,
    output logic [CNT_W-1:0] ccra,
    output logic [PER_W-1:0] ccrp
);

    typedef struct packed {
        tmr_mode_e        mode;
        logic             clr_sel;
        logic             swap;
        logic             en;
        pin_act_e         act;
        logic             init_lvl;
        logic [CNT_W-1:0] ccra;
        logic [PER_W-1:0] ccrp;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: begin
                    r_d.mode     = tmr_mode_e'(wr_data[CTL_MODE_LSB +: 2]);
                    r_d.clr_sel  = wr_data[CTL_CLRSEL];
                    r_d.swap     = wr_data[CTL_SWAP];
                    r_d.en       = wr_data[CTL_EN];
                    r_d.act      = pin_act_e'(wr_data[CTL_ACT_LSB +: 2]);
                    r_d.init_lvl = wr_data[CTL_INIT];
                end
                ADDR_CCRA: r_d.ccra = wr_data;
                ADDR_CCRP: r_d.ccrp = wr_data[PER_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mode     = r_q.mode;
    assign clr_sel  = r_q.clr_sel;
    assign swap     = r_q.swap;
    assign en       = r_q.en;
    assign act      = r_q.act;
    assign init_lvl = r_q.init_lvl;
    assign ccra     = r_q.ccra;
    assign ccrp     = r_q.ccrp;

    // R13: a P-value write keeps only the low data bits
    assert_ccrp_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CCRP) |=> (ccrp == $past(wr_data[PER_W-1:0])));

    // R13: an A-value write lands whole
    assert_ccra_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CCRA) |=> (ccra == $past(wr_data)));

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  tmr_mode_e        mode,
    input  logic             clr_sel,
    input  logic             en,
    input  logic [CNT_W-1:0] ccra,
    input  logic [PER_W-1:0] ccrp,
    input  logic             flag_clr_a,
    input  logic             flag_clr_p,
    output logic [CNT_W-1:0] count,
    output logic             flag_a,
    output logic             flag_p,
    output logic             a_hit
);

    localparam int LOW_W = CNT_W - PER_W;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fa;
        logic             fp;
    } core_t;

    core_t c_d, c_q;

    logic             run;
    logic             step;
    logic [CNT_W-1:0] raw;
    logic             a_match;
    logic             p_match;
    logic             clr_now;

    always_comb begin
        run     = en && (mode == MODE_CMP || mode == MODE_TMR);
        step    = run && tick;
        raw     = c_q.cnt + ONE;
        a_match = step && (ccra != '0) && (raw == ccra);
        p_match = step && (raw == {ccrp, {LOW_W{1'b0}}});
        clr_now = clr_sel ? a_match : p_match;

        c_d = c_q;
        if (!run)      c_d.cnt = '0;
        else if (step) c_d.cnt = clr_now ? '0 : raw;

        if (flag_clr_a)            c_d.fa = 1'b0;
        if (a_match)               c_d.fa = 1'b1;
        if (flag_clr_p)            c_d.fp = 1'b0;
        if (p_match && !clr_sel)   c_d.fp = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count  = c_q.cnt;
    assign flag_a = c_q.fa;
    assign flag_p = c_q.fp;
    assign a_hit  = a_match;

    assert_hold_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (count == '0));

    assert_idle_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CAP || mode == MODE_PWM) |=> (count == '0 && !$rose(flag_a) && !$rose(flag_p)));

    assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(count));

    assert_pwrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr_sel && count == {ccrp, {LOW_W{1'b0}}} - ONE) |=> (count == '0 && flag_p));

    assert_no_pflag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_sel |=> !$rose(flag_p));

    assert_ccra_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ccra == '0) |=> !$rose(flag_a));

endmodule

// File: rtl/tmr_pin.sv
module tmr_pin
    import tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  tmr_mode_e mode,
    input  pin_act_e  act,
    input  logic      init_lvl,
    input  logic      a_hit,
    output logic      pin
);

    typedef struct packed {
        logic lvl;
    } pin_t;

    pin_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (!en) begin
            p_d.lvl = init_lvl;
        end else if (mode == MODE_CMP && a_hit) begin
            case (act)
                PIN_LOW:  p_d.lvl = 1'b0;
                PIN_HIGH: p_d.lvl = 1'b1;
                PIN_FLIP: p_d.lvl = ~p_q.lvl;
                default:  p_d.lvl = p_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign pin = p_q.lvl;

    assert_pin_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pin == $past(init_lvl)));

    assert_tmr_mode_pin_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == MODE_TMR) |=> $stable(pin));

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             flag_clr_a_i,
    input  logic             flag_clr_p_i,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_a_o,
    output logic             flag_p_o,
    output logic             cmp_pin_o,
    output logic             roles_swap_o
);

    tmr_mode_e        mode;
    logic             clr_sel;
    logic             en;
    pin_act_e         act;
    logic             init_lvl;
    logic [CNT_W-1:0] ccra;
    logic [PER_W-1:0] ccrp;
    logic             a_hit;

    tmr_regs #(.CNT_W(CNT_W), .PER_W(PER_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_i),
        .wr_addr  (wr_addr_i),
        .wr_data  (wr_data_i),
        .mode     (mode),
        .clr_sel  (clr_sel),
        .swap     (roles_swap_o),
        .en       (en),
        .act      (act),
        .init_lvl (init_lvl),
        .ccra     (ccra),
        .ccrp     (ccrp)
    );

    tmr_core #(.CNT_W(CNT_W), .PER_W(PER_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_i),
        .mode       (mode),
        .clr_sel    (clr_sel),
        .en         (en),
        .ccra       (ccra),
        .ccrp       (ccrp),
        .flag_clr_a (flag_clr_a_i),
        .flag_clr_p (flag_clr_p_i),
        .count      (count_o),
        .flag_a     (flag_a_o),
        .flag_p     (flag_p_o),
        .a_hit      (a_hit)
    );

    tmr_pin u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .mode     (mode),
        .act      (act),
        .init_lvl (init_lvl),
        .a_hit    (a_hit),
        .pin      (cmp_pin_o)
    );

endmodule

// File: tb/sim_dual_cmp_timer.sv
module sim_dual_cmp_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  wa = 2'd0;
    logic [15:0] wd = 16'd0;
    logic        fca = 1'b0;
    logic        fcp = 1'b0;
    logic [15:0] cnt;
    logic        fa, fp, pin, swp;

    always #4 clk = ~clk;

    dual_cmp_timer u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .wr_en_i      (we),
        .wr_addr_i    (wa),
        .wr_data_i    (wd),
        .flag_clr_a_i (fca),
        .flag_clr_p_i (fcp),
        .count_o      (cnt),
        .flag_a_o     (fa),
        .flag_p_o     (fp),
        .cmp_pin_o    (pin),
        .roles_swap_o (swp)
    );

    int checks = 0;
    int errors = 0;

    logic [1:0]  m_mode = 2'd0, m_act = 2'd0;
    logic        m_clr = 1'b0, m_swap = 1'b0, m_en = 1'b0, m_init = 1'b0;
    logic        m_fa = 1'b0, m_fp = 1'b0, m_pin = 1'b0;
    logic [15:0] m_ccra = 16'd0, m_cnt = 16'd0;
    logic [7:0]  m_ccrp = 8'd0;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // reference model: one clock edge, computed from the requirements
    task automatic model_step();
        logic        run, am, pm;
        logic [15:0] raw;
        run = m_en && (m_mode == 2'b00 || m_mode == 2'b11);
        raw = m_cnt + 16'd1;
        am  = run && tick && (m_ccra != 16'd0) && (raw == m_ccra);
        pm  = run && tick && (raw == {m_ccrp, 8'h00});
        if (!m_en) m_pin = m_init;
        else if (am && m_mode == 2'b00) begin
            case (m_act)
                2'b01:   m_pin = 1'b0;
                2'b10:   m_pin = 1'b1;
                2'b11:   m_pin = ~m_pin;
                default: ;
            endcase
        end
        if (fca) m_fa = 1'b0;
        if (am)  m_fa = 1'b1;
        if (fcp) m_fp = 1'b0;
        if (pm && !m_clr) m_fp = 1'b1;
        if (!run) m_cnt = 16'd0;
        else if (tick) m_cnt = (m_clr ? am : pm) ? 16'd0 : raw;
        if (we) begin
            case (wa)
                2'd0: {m_init, m_act, m_en, m_swap, m_clr, m_mode} = wd[7:0];
                2'd1: m_ccra = wd;
                2'd2: m_ccrp = wd[7:0];
                default: ;
            endcase
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R3", "count", 32'(cnt), 32'(m_cnt));
        check("R9", "flag_a", 32'(fa), 32'(m_fa));
        check("R9", "flag_p", 32'(fp), 32'(m_fp));
        check("R10", "pin", 32'(pin), 32'(m_pin));
        check("R12", "swap", 32'(swp), 32'(m_swap));
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        tick = 1'b0; we = 1'b1; wa = a; wd = d;
        cyc();
        we = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        tick = 1'b1;
        repeat (n) cyc();
        tick = 1'b0;
    endtask

    task automatic clear_flags();
        tick = 1'b0; fca = 1'b1; fcp = 1'b1;
        cyc();
        fca = 1'b0; fcp = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1", "count", 32'(cnt), 32'd0);
        check("R1", "flag_a", 32'(fa), 32'd0);
        check("R1", "flag_p", 32'(fp), 32'd0);
        check("R1", "pin", 32'(pin), 32'd0);
        check("R1", "swap", 32'(swp), 32'd0);

        // R2: disabled, starting level 1, ticks ignored
        wr(2'd0, 16'h0080);
        run_ticks(3);
        check("R2", "count held", 32'(cnt), 32'd0);
        check("R2", "pin init", 32'(pin), 32'd1);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0100);
        check("R2", "pin init low", 32'(pin), 32'd0);
        wr(2'd2, 16'h0302);              // R13: only low byte kept, P = 2
        wr(2'd0, 16'h0070);              // mode 00, enable, toggle
        run_ticks(256);
        check("R7", "count at A", 32'(cnt), 32'h100);
        check("R7", "flag_a", 32'(fa), 32'd1);
        check("R7", "flag_p", 32'(fp), 32'd0);
        check("R10", "pin toggled", 32'(pin), 32'd1);
        run_ticks(255);
        check("R4", "count before wrap", 32'(cnt), 32'h1FF);
        run_ticks(1);
        check("R4", "count wrapped", 32'(cnt), 32'd0);
        check("R13", "flag_p at 512", 32'(fp), 32'd1);

        clear_flags();
        check("R9", "flag_a cleared", 32'(fa), 32'd0);
        check("R9", "flag_p cleared", 32'(fp), 32'd0);

        // R3: capture code idles the counter
        wr(2'd0, 16'h0011);
        run_ticks(10);
        check("R3", "idle count", 32'(cnt), 32'd0);
        check("R3", "idle flag_a", 32'(fa), 32'd0);

        // R6: clear on A, pin driven low
        wr(2'd1, 16'd5);
        wr(2'd2, 16'd0);
        wr(2'd0, 16'h0034);
        run_ticks(4);
        check("R6", "count before A", 32'(cnt), 32'd4);
        check("R6", "flag_a early", 32'(fa), 32'd0);
        run_ticks(1);
        check("R6", "count cleared", 32'(cnt), 32'd0);
        check("R6", "flag_a", 32'(fa), 32'd1);
        check("R10", "pin low", 32'(pin), 32'd0);
        clear_flags();
        wr(2'd2, 16'd1);
        wr(2'd1, 16'h0180);
        run_ticks(16'h180);
        check("R6", "count period A", 32'(cnt), 32'd0);
        check("R6", "flag_a set", 32'(fa), 32'd1);
        check("R6", "flag_p suppressed", 32'(fp), 32'd0);

        // R11: timer/counter mode leaves pin alone
        clear_flags();
        wr(2'd1, 16'd3);
        wr(2'd0, 16'h0077);
        run_ticks(3);
        check("R11", "count cleared", 32'(cnt), 32'd0);
        check("R11", "flag_a", 32'(fa), 32'd1);
        check("R11", "pin unchanged", 32'(pin), 32'd0);

        // R12: role swap bit
        wr(2'd0, 16'h0008);
        check("R12", "swap set", 32'(swp), 32'd1);
        wr(2'd0, 16'h0000);
        check("R12", "swap clear", 32'(swp), 32'd0);

        // R5 and R8: full wrap with both compare values zero
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd0);
        clear_flags();
        wr(2'd0, 16'h0010);
        run_ticks(65535);
        check("R5", "count top", 32'(cnt), 32'hFFFF);
        check("R5", "flag_p before wrap", 32'(fp), 32'd0);
        run_ticks(1);
        check("R5", "count wrapped", 32'(cnt), 32'd0);
        check("R5", "flag_p", 32'(fp), 32'd1);
        check("R8", "flag_a never", 32'(fa), 32'd0);

        // random phase, model checked every cycle
        for (int i = 0; i < 20000; i++) begin
            logic [31:0] rv;
            rv   = $urandom;
            tick = (rv[1:0] != 2'b00);
            fca  = (rv[5:2] == 4'd0);
            fcp  = (rv[9:6] == 4'd0);
            we   = (rv[15:10] == 6'd0);
            wa   = 2'(rv[17:16] % 2'd3);
            case (wa)
                2'd0:    wd = 16'((rv[31:24] & 8'hEF) | ((rv[19:18] != 2'b00) ? 8'h10 : 8'h00));
                2'd1:    wd = 16'($urandom % 700);
                default: wd = 16'($urandom % 4);
            endcase
            cyc();
        end
        tick = 1'b0; fca = 1'b0; fcp = 1'b0; we = 1'b0;
        cyc();

        summary();
        $finish;
    end

endmodule